// File: doc/BRIEF.md
# Transmit Link-Layer Sequencer for a Multi-Lane Serial Converter Link

This block produces the per-lane octet stream of the link layer on the transmit side of a JESD204B converter link. Each lane carries four octets per link-clock cycle on a 32-bit word, together with a 4-bit flag that marks which octets are control characters. The block takes an active-low synchronisation request from the far-end receiver, the frame size F and the multiframe length K, a bank of link-parameter octets and one user word per lane. It sequences the lanes through three phases: comma transmission while the receiver asks for sync, a four-multiframe alignment preamble, and then user data.

Multiframe timing comes from a local multiframe counter that starts at zero when reset ends and advances four octets per cycle, wrapping every F*K octets. The preamble always starts on one of its boundaries. The second preamble multiframe carries fourteen parameter octets: thirteen taken from the bank with the lane number inserted, plus a checksum. A long reassertion of the sync request during the preamble or data sends the lanes back to commas and latches an error flag. An invalid F/K pair holds the link in the comma phase and raises the same flag.

Top module: `jtx_link_seq`

## Requirements
- R1: While the sequencer is in the comma phase (including reset and whenever `sync_n` is low before the preamble), every lane word is 0xBCBCBCBC, every lane control nibble is 4'hF and `data_phase` is low.
- R2: The multiframe position is 4*c mod (F*K) in the c-th cycle after reset ends. After `sync_n` goes high, the comma phase lasts until at least F+9 comma octets have been sent with `sync_n` high. The preamble then starts at the first multiframe boundary after that point.
- R3: The preamble lasts exactly four multiframes. In each of them, position 0 carries 0x1C and position F*K-1 carries 0x7C, both with their control bit set.
- R4: In the second preamble multiframe, position 1 carries 0x9C with its control bit set, and positions 2 to 15 carry parameter octets 0 to 13 with their control bits clear. Parameter octet n (n<13) is `cfg_octets[8n+7:8n]`, except that bits [4:0] of parameter octet 2 are replaced by the lane index. Parameter octet 13 is the sum of parameter octets 0 to 12 modulo 256.
- R5: Every other preamble octet carries the low 8 bits of its position in the multiframe, with its control bit clear.
- R6: The cycle after the last word of the fourth preamble multiframe starts the data phase. In the data phase each lane word equals its 32-bit slice of `tx_data` in the same cycle, the control nibble is zero and `data_phase` is high.
- R7: Octet i of a lane word occupies bits [8i+7:8i], and its control flag is bit i of that lane's nibble. Octet 0 is the earliest in the stream.
- R8: During the preamble or data phase, `sync_n` low for at most 4*F consecutive octets has no effect. If it stays low in the cycle that takes the count above 4*F, the lanes carry commas from the next cycle.
- R9: `err_irq` is high while the configuration is invalid: F=0, F>16, K=0, K>32, F*K not a multiple of 4, or F*K<20. An invalid configuration holds the comma phase. `err_irq` also goes high the cycle after a return forced by R8, and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_n | input | 1 | Synchronisation request from the receiver, active low |
| cfg_f | input | 8 | Octets per frame F |
| cfg_k | input | 6 | Frames per multiframe K |
| cfg_octets | input | 104 | Link-parameter octets 0 to 12, octet n in bits [8n+7:8n] |
| tx_data | input | 32*LANES | User words, lane l in bits [32l+31:32l] |
| lane_data | output | 32*LANES | Per-lane link octets, lane l in bits [32l+31:32l] |
| lane_ctrl | output | 4*LANES | Per-octet control flags, lane l in bits [4l+3:4l] |
| data_phase | output | 1 | High while user data is being sent |
| err_irq | output | 1 | Error flag for invalid configuration or forced resync |

## Verification
The bench sweeps several F/K pairs and several release times relative to the multiframe counter, and predicts every octet of every lane arithmetically. A design that counted the comma hold wrongly would start the preamble one multiframe early or late. One that ignored the multiframe phase would start it off a boundary. An off-by-one in the second multiframe would shift the lane number or the checksum into the wrong position. A short drop of `sync_n` in data must leave the data untouched, while one drop longer than 4*F octets must produce commas exactly two cycles past the threshold count. Two invalid F/K pairs must stay on commas with the error flag high.

// File: rtl/jtx_pkg.sv
package jtx_pkg;
  localparam int JTX_MAX_F = 16;
  localparam int JTX_K_MAX = 32;
  localparam int JTX_POS_W = $clog2(JTX_MAX_F * JTX_K_MAX + 1);
  localparam int JTX_CFG_N = 13;
  localparam int JTX_CFG_W = 8 * JTX_CFG_N;
  localparam int JTX_MIN_MF = 20;

  typedef enum logic [1:0] {
    ST_CGS  = 2'd0,
    ST_ILAS = 2'd1,
    ST_DATA = 2'd2
  } jtx_state_e;

  localparam logic [7:0] CH_K = 8'hBC;
  localparam logic [7:0] CH_R = 8'h1C;
  localparam logic [7:0] CH_Q = 8'h9C;
  localparam logic [7:0] CH_A = 8'h7C;

  // Configuration legality: bounded F and K, whole words per multiframe,
  // and room for the parameter block inside one multiframe.
  function automatic logic cfg_valid(input logic [7:0] f, input logic [5:0] k);
    int prod;
    prod = int'(f) * int'(k);
    return (int'(f) >= 1) && (int'(f) <= JTX_MAX_F) &&
           (int'(k) >= 1) && (int'(k) <= JTX_K_MAX) &&
           (prod % 4 == 0) && (prod >= JTX_MIN_MF);
  endfunction

  // Parameter octet idx (0..13) for a lane; 13 is the modulo-256 checksum.
  function automatic logic [7:0] cfg_octet(input logic [JTX_CFG_W-1:0] base,
                                           input int lane, input int idx);
    logic [7:0] sum, cur, pick;
    logic [4:0] lid;
    sum  = 8'd0;
    pick = 8'd0;
    lid  = 5'(lane);
    for (int n = 0; n < JTX_CFG_N; n++) begin
      cur = base[8*n +: 8];
      if (n == 2) cur = {cur[7:5], lid};
      sum = sum + cur;
      if (n == idx) pick = cur;
    end
    if (idx == JTX_CFG_N) pick = sum;
    return pick;
  endfunction

  // Preamble octet at position p of multiframe mf: {ctrl, octet}.
  function automatic logic [8:0] ilas_char(input logic [JTX_POS_W-1:0] p,
                                           input logic [1:0] mf,
                                           input logic [JTX_POS_W-1:0] mflen,
                                           input logic [7:0] cfgo);
    if (p == '0) return {1'b1, CH_R};
    if (p == mflen - JTX_POS_W'(1)) return {1'b1, CH_A};
    if (mf == 2'd1 && p == JTX_POS_W'(1)) return {1'b1, CH_Q};
    if (mf == 2'd1 && p >= JTX_POS_W'(2) && p <= JTX_POS_W'(15)) return {1'b0, cfgo};
    return {1'b0, p[7:0]};
  endfunction
endpackage

// File: rtl/jtx_lmfc.sv
module jtx_lmfc
  import jtx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [JTX_POS_W-1:0] mf_len,
  output logic [JTX_POS_W-1:0] pos,
  output logic                 mf_wrap
);
  localparam logic [JTX_POS_W-1:0] STEP = JTX_POS_W'(4);

  // mf_wrap marks the last word of the current multiframe.
  assign mf_wrap = (pos + STEP >= mf_len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pos <= '0;
    else if (mf_wrap) pos <= '0;
    else              pos <= pos + STEP;
  end
endmodule

// File: rtl/jtx_seq_fsm.sv
module jtx_seq_fsm
  import jtx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sync_n,
  input  logic [7:0] cfg_f,
  input  logic       cfg_bad,
  input  logic       mf_wrap,
  output jtx_state_e state,
  output logic [1:0] mf_idx,
  output logic       err_flag
);
  logic [7:0] kcnt, lowcnt, k_inc, low_inc;
  logic       ilas_go, resync_req, err_seen;

  function automatic logic [7:0] add4_sat(input logic [7:0] x);
    return (x > 8'd251) ? 8'hFF : x + 8'd4;
  endfunction

  assign k_inc   = add4_sat(kcnt);
  assign low_inc = add4_sat(lowcnt);

  // Leave commas once F+9 released octets have gone out and the next word
  // opens a multiframe.
  assign ilas_go = (state == ST_CGS) && sync_n && !cfg_bad && mf_wrap &&
                   ({1'b0, k_inc} >= ({1'b0, cfg_f} + 9'd9));
  // A drop longer than four frames restarts synchronisation.
  assign resync_req = (state != ST_CGS) && !sync_n &&
                      ({2'b00, low_inc} > {cfg_f, 2'b00});
  assign err_flag = err_seen | cfg_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_CGS;
      mf_idx   <= 2'd0;
      kcnt     <= 8'd0;
      lowcnt   <= 8'd0;
      err_seen <= 1'b0;
    end else begin
      lowcnt <= sync_n ? 8'd0 : low_inc;
      if (resync_req) err_seen <= 1'b1;
      if (cfg_bad || resync_req) begin
        state  <= ST_CGS;
        kcnt   <= 8'd0;
        mf_idx <= 2'd0;
      end else begin
        case (state)
          ST_CGS: begin
            kcnt <= sync_n ? k_inc : 8'd0;
            if (ilas_go) begin
              state  <= ST_ILAS;
              mf_idx <= 2'd0;
            end
          end
          ST_ILAS: begin
            if (mf_wrap) begin
              if (mf_idx == 2'd3) state <= ST_DATA;
              else                mf_idx <= mf_idx + 2'd1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R8: a single-cycle drop in data never leaves the data phase
  a_r8_short_drop_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DATA && !sync_n && $past(sync_n) && !cfg_bad) |=> state == ST_DATA);
endmodule

// File: rtl/jtx_lane_fmt.sv
module jtx_lane_fmt
  import jtx_pkg::*;
#(
  parameter int LANE = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  jtx_state_e           state,
  input  logic [1:0]           mf_idx,
  input  logic [JTX_POS_W-1:0] pos,
  input  logic [JTX_POS_W-1:0] mf_len,
  input  logic [JTX_CFG_W-1:0] cfg_octets,
  input  logic [31:0]          user_word,
  output logic [31:0]          lane_word,
  output logic [3:0]           lane_ctrl
);
  for (genvar i = 0; i < 4; i++) begin : g_oct
    logic [JTX_POS_W-1:0] p;
    logic [8:0]           ch;
    logic [7:0]           oct;
    logic                 ctl;
    always_comb begin
      p  = pos + JTX_POS_W'(i);
      ch = ilas_char(p, mf_idx, mf_len, cfg_octet(cfg_octets, LANE, int'(p) - 2));
      case (state)
        ST_ILAS: begin oct = ch[7:0];            ctl = ch[8]; end
        ST_DATA: begin oct = user_word[8*i +: 8]; ctl = 1'b0;  end
        default: begin oct = CH_K;               ctl = 1'b1;  end
      endcase
    end
    assign lane_word[8*i +: 8] = oct;
    assign lane_ctrl[i]        = ctl;
  end

  // R1: comma phase sends only flagged commas
  a_r1_cgs_comma: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_CGS |-> (lane_ctrl == 4'hF && lane_word == {4{CH_K}}));
  // R6: data phase forwards the user word with no control flags
  a_r6_data_clean: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_DATA |-> (lane_ctrl == 4'h0 && lane_word == user_word));
endmodule

// File: rtl/jtx_link_seq.sv
module jtx_link_seq
  import jtx_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sync_n,
  input  logic [7:0]             cfg_f,
  input  logic [5:0]             cfg_k,
  input  logic [JTX_CFG_W-1:0]   cfg_octets,
  input  logic [32*LANES-1:0]    tx_data,
  output logic [32*LANES-1:0]    lane_data,
  output logic [4*LANES-1:0]     lane_ctrl,
  output logic                   data_phase,
  output logic                   err_irq
);
  logic [JTX_POS_W-1:0] mf_len, pos;
  logic                 mf_wrap, cfg_bad, in_ilas;
  logic [1:0]           mf_idx;
  jtx_state_e           state;

  assign cfg_bad    = !cfg_valid(cfg_f, cfg_k);
  assign mf_len     = JTX_POS_W'({6'd0, cfg_f} * {8'd0, cfg_k});
  assign data_phase = (state == ST_DATA);
  assign in_ilas    = (state == ST_ILAS);

  jtx_lmfc u_lmfc (
    .clk(clk), .rst_n(rst_n), .mf_len(mf_len), .pos(pos), .mf_wrap(mf_wrap)
  );

  jtx_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .cfg_f(cfg_f), .cfg_bad(cfg_bad),
    .mf_wrap(mf_wrap), .state(state), .mf_idx(mf_idx), .err_flag(err_irq)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    jtx_lane_fmt #(.LANE(l)) u_fmt (
      .clk(clk), .rst_n(rst_n), .state(state), .mf_idx(mf_idx), .pos(pos),
      .mf_len(mf_len), .cfg_octets(cfg_octets), .user_word(tx_data[32*l +: 32]),
      .lane_word(lane_data[32*l +: 32]), .lane_ctrl(lane_ctrl[4*l +: 4])
    );
  end

  // R2: the preamble opens at multiframe position zero, only after release
  a_r2_ilas_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ilas) |-> (pos == '0 && $past(sync_n)));
  // R3: data follows the fourth preamble multiframe, on a boundary
  a_r3_four_multiframes: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_phase) |-> ($past(mf_idx) == 2'd3 && $past(in_ilas) && pos == '0));
  // R8: leaving data with a legal configuration needs a low sync request
  a_r8_resync_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(data_phase) && !cfg_bad) |-> $past(!sync_n));
  // R9: an invalid configuration holds the comma phase with the flag up
  a_r9_bad_cfg_holds: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_bad |=> (state == ST_CGS && err_irq));
endmodule

// File: tb/sim_jtx_link_seq.sv
module sim_jtx_link_seq;
  localparam int LANES = 2;
  localparam logic [103:0] CFG = 104'h0D_0C_0B_0A_09_08_07_06_05_E3_A7_42_11;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 sync_n = 1'b0;
  logic [7:0]           cfg_f = 8'd2;
  logic [5:0]           cfg_k = 6'd16;
  logic [103:0]         cfg_octets = CFG;
  logic [32*LANES-1:0]  tx_data = '0;
  logic [32*LANES-1:0]  lane_data;
  logic [4*LANES-1:0]   lane_ctrl;
  logic                 data_phase, err_irq;

  int vectors = 0;
  int fails = 0;

  always #4 clk = ~clk;

  jtx_link_seq #(.LANES(LANES)) u0 (
    .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .cfg_f(cfg_f), .cfg_k(cfg_k),
    .cfg_octets(cfg_octets), .tx_data(tx_data), .lane_data(lane_data),
    .lane_ctrl(lane_ctrl), .data_phase(data_phase), .err_irq(err_irq)
  );

  function automatic logic [31:0] user_word(input int cc, input int lane);
    return (32'(cc) * 32'h0100_0193) ^ (32'(lane) << 28) ^ 32'h5A00_00A5;
  endfunction

  function automatic logic legal(input int f, input int k);
    return f >= 1 && f <= 16 && k >= 1 && k <= 32 && (f*k) % 4 == 0 && f*k >= 20;
  endfunction

  // Parameter octet idx for a lane, restated from R4.
  function automatic logic [7:0] param_octet(input int lane, input int idx);
    logic [7:0] v [13];
    logic [7:0] acc;
    acc = 8'd0;
    for (int n = 0; n < 13; n++) v[n] = CFG[8*n +: 8];
    v[2] = (v[2] & 8'hE0) | 8'(lane & 31);
    for (int n = 0; n < 13; n++) acc = acc + v[n];
    return (idx == 13) ? acc : v[idx];
  endfunction

  // Expected {ctrl, octet} for octet i of lane at cycle cc; s = preamble start.
  function automatic logic [8:0] exp_oct(input int cc, input int s, input int mfl,
                                         input int lane, input int i);
    int q, mf, p;
    logic [31:0] w;
    if (cc < s) return {1'b1, 8'hBC};
    q = (cc - s) * 4 + i;
    if (q >= 4 * mfl) begin
      w = user_word(cc, lane);
      return {1'b0, w[8*i +: 8]};
    end
    mf = q / mfl;
    p  = q % mfl;
    if (p == mfl - 1) return {1'b1, 8'h7C};
    if (p == 0)       return {1'b1, 8'h1C};
    if (mf == 1 && p == 1) return {1'b1, 8'h9C};
    if (mf == 1 && p >= 2 && p <= 15) return {1'b0, param_octet(lane, p - 2)};
    return {1'b0, 8'(p)};
  endfunction

  function automatic int start_cycle(input int f, input int k, input int rel);
    int t = rel;
    while (!(((t - rel + 1) * 4 >= f + 9) && (((t + 1) * 4) % (f * k) == 0))) t++;
    return t + 1;
  endfunction

  task automatic check_bit(input logic act, input logic exp, input string tag, input string what);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
    end
  endtask

  task automatic check_lanes(input int cc, input int s, input int mfl, input logic force_k);
    logic [31:0] ew;
    logic [3:0]  ec;
    logic [8:0]  e;
    string tag;
    for (int l = 0; l < LANES; l++) begin
      for (int i = 0; i < 4; i++) begin
        e = force_k ? {1'b1, 8'hBC} : exp_oct(cc, s, mfl, l, i);
        ew[8*i +: 8] = e[7:0];
        ec[i] = e[8];
      end
      if (force_k)                 tag = "R8";
      else if (cc < s)             tag = "R1/R2";
      else if (cc < s + mfl)       tag = "R3/R5/R7";
      else if (cc < s + 4 * mfl / 4 + 0 && 0) tag = "R3";
      else if ((cc - s) * 4 < 4 * mfl) tag = "R3/R4/R5";
      else                         tag = "R6/R7";
      vectors++;
      if (lane_data[32*l +: 32] !== ew || lane_ctrl[4*l +: 4] !== ec) begin
        fails++;
        $display("FAIL %s cycle %0d lane %0d: actual %h/%h expected %h/%h",
                 tag, cc, l, lane_data[32*l +: 32], lane_ctrl[4*l +: 4], ew, ec);
      end
    end
  endtask

  task automatic do_reset(input int f, input int k);
    cfg_f  = 8'(f);
    cfg_k  = 6'(k);
    rst_n  = 1'b0;
    sync_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    for (int l = 0; l < LANES; l++) begin
      vectors++;
      if (lane_data[32*l +: 32] !== 32'hBCBCBCBC || lane_ctrl[4*l +: 4] !== 4'hF) begin
        fails++;
        $display("FAIL R1 reset lane %0d: actual %h/%h expected bcbcbcbc/f",
                 l, lane_data[32*l +: 32], lane_ctrl[4*l +: 4]);
      end
    end
    check_bit(data_phase, 1'b0, "R1", "reset data_phase");
    check_bit(err_irq, !legal(f, k), "R9", "reset err_irq");
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Full link bring-up: commas, preamble, data, with release after hold cycles.
  task automatic run_link(input int f, input int k, input int hold);
    int mfl = f * k;
    int s = start_cycle(f, k, hold);
    do_reset(f, k);
    for (int cc = 0; cc < s + mfl + 6; cc++) begin
      if (cc > 0) @(negedge clk);
      sync_n = (cc >= hold);
      for (int l = 0; l < LANES; l++) tx_data[32*l +: 32] = user_word(cc, l);
      #1;
      check_lanes(cc, s, mfl, 1'b0);
      check_bit(data_phase, (cc >= s + mfl), (cc >= s + mfl) ? "R6" : "R2/R3", "data_phase");
      check_bit(err_irq, 1'b0, "R9", "err_irq in clean run");
    end
  endtask

  task automatic run_resync();
    int f = 2, k = 16;
    int mfl = f * k;
    int s = start_cycle(f, k, 0);
    int d0 = s + mfl;
    do_reset(f, k);
    for (int cc = 0; cc <= d0 + 16; cc++) begin
      logic low;
      if (cc > 0) @(negedge clk);
      low = (cc == d0 + 4) || (cc == d0 + 5) || (cc >= d0 + 10 && cc <= d0 + 15);
      sync_n = !low;
      for (int l = 0; l < LANES; l++) tx_data[32*l +: 32] = user_word(cc, l);
      #1;
      if (cc >= d0 + 13 && cc <= d0 + 15) begin
        check_lanes(cc, s, mfl, 1'b1);
        check_bit(data_phase, 1'b0, "R8", "data_phase after long drop");
        check_bit(err_irq, 1'b1, "R9", "err_irq after forced resync");
      end else if (cc <= d0 + 12) begin
        check_lanes(cc, s, mfl, 1'b0);
        check_bit(err_irq, 1'b0, "R8", "err_irq before threshold");
      end else begin
        check_bit(err_irq, 1'b1, "R9", "err_irq held until reset");
      end
    end
  endtask

  task automatic run_bad(input int f, input int k);
    do_reset(f, k);
    for (int cc = 0; cc < 80; cc++) begin
      if (cc > 0) @(negedge clk);
      sync_n = 1'b1;
      #1;
      check_lanes(cc, 1 << 30, 32, 1'b0);
      check_bit(err_irq, 1'b1, "R9", "err_irq on invalid configuration");
      check_bit(data_phase, 1'b0, "R9", "data_phase on invalid configuration");
    end
  endtask

  initial begin
    #1_500_000;
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int fl[5] = '{1, 2, 4, 2, 8};
    int kl[5] = '{32, 32, 32, 16, 4};
    for (int c = 0; c < 5; c++)
      for (int h = 0; h < 8; h++)
        run_link(fl[c], kl[c], h * 3);
    run_resync();
    run_bad(3, 5);
    run_bad(1, 16);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule